// File: doc/BRIEF.md
# SHA-256 Compression Engine

This block runs the 64 SHA-256 compression rounds over one already-padded 512-bit chunk and keeps the running chaining value from one chunk to the next. A controller starts a chunk by raising the start input for one cycle. It then presents the sixteen 32-bit message words, one per cycle, on the next sixteen cycles. The block expands the rest of the message schedule itself and adds each round constant from its own table. It pipelines the round work into three register stages that overlap with the word input, so every chunk takes exactly 67 cycles from start to the ready pulse.

The chaining value is not cleared between chunks, so the chunks of one message follow each other without any help from software. An asynchronous reset loads the standard initial hash values before each new message. A separate read request sends the eight digest words out one after another on the word port. That readout may run at the same time as the word input of the next chunk.

Top module: `sha256_engine`

## Requirements
- R1: While `rst_ni` is low, `ready_o` and `word_valid_o` are 0 and any chunk in progress is abandoned. After reset the eight hash words hold 6a09e667, bb67ae85, 3c6ef372, a54ff53a, 510e527f, 9b05688c, 1f83d9ab, 5be0cd19 (H0 first).
- R2: A start accepted at clock edge N takes message word t (t = 0..15, word 0 being the most significant 32 bits of the chunk) from `word_i` at edge N+1+t.
- R3: For a start accepted at edge N, `ready_o` is high for exactly the one cycle that follows edge N+67. A start raised during that cycle is accepted at edge N+68.
- R4: After a chunk, the hash words equal the standard SHA-256 compression of the previous hash words with the sixteen message words.
- R5: Successive chunks chain without a reset: each chunk starts from the hash words left by the one before.
- R6: A read accepted at edge M makes `word_valid_o` high for the eight cycles after edges M..M+7. `hash_word_o` carries H0 through H7 in that order, and `word_valid_o` then returns to 0.
- R7: `read_i` is ignored from the start edge of a chunk through its final edge (N+1..N+67) and while a readout is running.
- R8: `start_i` is ignored while a chunk is in progress. Words and the ready timing of the running chunk are unaffected.
- R9: A read and a start may be accepted at the same edge. The readout then delivers the digest as it was before the new chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, loads the initial hash values |
| start_i | input | 1 | Starts a chunk when the engine is idle |
| word_i | input | 32 | Message word stream, one word per cycle after a start |
| read_i | input | 1 | Requests the word-serial digest readout |
| ready_o | output | 1 | One-cycle pulse when a chunk has been folded into the hash |
| word_valid_o | output | 1 | Marks a digest word on hash_word_o |
| hash_word_o | output | 32 | Digest word, H0 first |

## Verification
The readout of the previous digest and the word input of the next chunk can fall in the same cycles. The bench raises `start_i` and `read_i` together in the cycle where `ready_o` pulses. It then compares each streamed word with its own model of the earlier digest while it feeds the new chunk's words. It finally reads the chained digest after that chunk and compares it with the model, and it checks that the ready pulse still lands 67 cycles after the start.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned ROUNDS       = 64;
  localparam int unsigned BLK_WORDS    = 16;
  localparam int unsigned DIG_WORDS    = 8;
  localparam int unsigned PIPE_FILL    = 3;
  localparam int unsigned CHUNK_CYCLES = ROUNDS + PIPE_FILL;
  localparam int unsigned STEP_W       = $clog2(CHUNK_CYCLES + 1);
  localparam int unsigned RIDX_W       = $clog2(ROUNDS);
  localparam int unsigned BIDX_W       = $clog2(BLK_WORDS);
  localparam int unsigned DIDX_W       = $clog2(DIG_WORDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } state_t;

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t sml_s0(word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sml_s1(word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(word_t x, word_t y, word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t majority(word_t x, word_t y, word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  // 3:2 compressor row: sum and shifted carry, no carry ripple
  function automatic word_t csa_sum(word_t x, word_t y, word_t z);
    return x ^ y ^ z;
  endfunction

  function automatic word_t csa_cry(word_t x, word_t y, word_t z);
    return ((x & y) | (x & z) | (y & z)) << 1;
  endfunction

  function automatic word_t round_k(logic [RIDX_W-1:0] idx);
    word_t k;
    case (int'(idx))
      0:  k = 32'h428a2f98;  1: k = 32'h71374491;  2: k = 32'hb5c0fbcf;  3: k = 32'he9b5dba5;
      4:  k = 32'h3956c25b;  5: k = 32'h59f111f1;  6: k = 32'h923f82a4;  7: k = 32'hab1c5ed5;
      8:  k = 32'hd807aa98;  9: k = 32'h12835b01; 10: k = 32'h243185be; 11: k = 32'h550c7dc3;
      12: k = 32'h72be5d74; 13: k = 32'h80deb1fe; 14: k = 32'h9bdc06a7; 15: k = 32'hc19bf174;
      16: k = 32'he49b69c1; 17: k = 32'hefbe4786; 18: k = 32'h0fc19dc6; 19: k = 32'h240ca1cc;
      20: k = 32'h2de92c6f; 21: k = 32'h4a7484aa; 22: k = 32'h5cb0a9dc; 23: k = 32'h76f988da;
      24: k = 32'h983e5152; 25: k = 32'ha831c66d; 26: k = 32'hb00327c8; 27: k = 32'hbf597fc7;
      28: k = 32'hc6e00bf3; 29: k = 32'hd5a79147; 30: k = 32'h06ca6351; 31: k = 32'h14292967;
      32: k = 32'h27b70a85; 33: k = 32'h2e1b2138; 34: k = 32'h4d2c6dfc; 35: k = 32'h53380d13;
      36: k = 32'h650a7354; 37: k = 32'h766a0abb; 38: k = 32'h81c2c92e; 39: k = 32'h92722c85;
      40: k = 32'ha2bfe8a1; 41: k = 32'ha81a664b; 42: k = 32'hc24b8b70; 43: k = 32'hc76c51a3;
      44: k = 32'hd192e819; 45: k = 32'hd6990624; 46: k = 32'hf40e3585; 47: k = 32'h106aa070;
      48: k = 32'h19a4c116; 49: k = 32'h1e376c08; 50: k = 32'h2748774c; 51: k = 32'h34b0bcb5;
      52: k = 32'h391c0cb3; 53: k = 32'h4ed8aa4a; 54: k = 32'h5b9cca4f; 55: k = 32'h682e6ff3;
      56: k = 32'h748f82ee; 57: k = 32'h78a5636f; 58: k = 32'h84c87814; 59: k = 32'h8cc70208;
      60: k = 32'h90befffa; 61: k = 32'ha4506ceb; 62: k = 32'hbef9a3f7; 63: k = 32'hc67178f2;
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic word_t iv_word(logic [DIDX_W-1:0] idx);
    word_t v;
    case (int'(idx))
      0: v = 32'h6a09e667; 1: v = 32'hbb67ae85; 2: v = 32'h3c6ef372; 3: v = 32'ha54ff53a;
      4: v = 32'h510e527f; 5: v = 32'h9b05688c; 6: v = 32'h1f83d9ab; 7: v = 32'h5be0cd19;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
  import sha256_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              load_o,
  output logic              busy_o,
  output logic              sa_en_o,
  output logic [RIDX_W-1:0] sa_idx_o,
  output logic              sb_en_o,
  output logic              sb_first_o,
  output logic              rnd_en_o,
  output logic              fin_o,
  output logic              ready_o
);
  localparam logic [STEP_W-1:0] SA_LO  = STEP_W'(1);
  localparam logic [STEP_W-1:0] SA_HI  = STEP_W'(ROUNDS);
  localparam logic [STEP_W-1:0] SB_LO  = STEP_W'(2);
  localparam logic [STEP_W-1:0] SB_HI  = STEP_W'(ROUNDS + 1);
  localparam logic [STEP_W-1:0] RD_LO  = STEP_W'(3);
  localparam logic [STEP_W-1:0] RD_HI  = STEP_W'(ROUNDS + 2);
  localparam logic [STEP_W-1:0] LAST   = STEP_W'(CHUNK_CYCLES);

  logic              busy_q, ready_q;
  logic [STEP_W-1:0] step_q;
  logic              accept, fin;

  assign accept = start_i & ~busy_q;
  assign fin    = busy_q && (step_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= fin;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= SA_LO;
      end else if (fin) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + STEP_W'(1);
      end
    end
  end

  assign load_o     = accept;
  assign busy_o     = busy_q;
  assign sa_en_o    = busy_q && (step_q >= SA_LO) && (step_q <= SA_HI);
  assign sa_idx_o   = RIDX_W'(step_q - SA_LO);
  assign sb_en_o    = busy_q && (step_q >= SB_LO) && (step_q <= SB_HI);
  assign sb_first_o = (step_q == SB_LO);
  assign rnd_en_o   = busy_q && (step_q >= RD_LO) && (step_q <= RD_HI);
  assign fin_o      = fin;
  assign ready_o    = ready_q;
endmodule

// File: rtl/sha256_sched.sv
module sha256_sched
  import sha256_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sa_en_i,
  input  logic [RIDX_W-1:0] sa_idx_i,
  input  word_t             word_i,
  output word_t             wk_o
);
  word_t win_q [BLK_WORDS];
  word_t wk_q;
  word_t r1_s, r1_c, r2_s, r2_c, w_exp, w_new;

  // W_t = s1(W_t-2) + W_t-7 + s0(W_t-15) + W_t-16, two compressor rows then one add
  always_comb begin
    r1_s  = csa_sum(sml_s1(win_q[BLK_WORDS-2]), win_q[BLK_WORDS-7], sml_s0(win_q[1]));
    r1_c  = csa_cry(sml_s1(win_q[BLK_WORDS-2]), win_q[BLK_WORDS-7], sml_s0(win_q[1]));
    r2_s  = csa_sum(r1_s, r1_c, win_q[0]);
    r2_c  = csa_cry(r1_s, r1_c, win_q[0]);
    w_exp = r2_s + r2_c;
    w_new = (sa_idx_i < RIDX_W'(BLK_WORDS)) ? word_i : w_exp;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BLK_WORDS; i++) win_q[i] <= '0;
      wk_q <= '0;
    end else if (sa_en_i) begin
      for (int i = 0; i < BLK_WORDS - 1; i++) win_q[i] <= win_q[i+1];
      win_q[BLK_WORDS-1] <= w_new;
      wk_q <= w_new + round_k(sa_idx_i);
    end
  end

  assign wk_o = wk_q;
endmodule

// File: rtl/sha256_round.sv
module sha256_round
  import sha256_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  state_t seed_i,
  input  logic   sb_en_i,
  input  logic   sb_first_i,
  input  logic   rnd_en_i,
  input  word_t  wk_i,
  output state_t state_o
);
  state_t st_q, nxt;
  word_t  pk_q;
  word_t  s1v, chv, s0v, mjv;
  word_t  t_s, t_c, e_s, e_c, u_s, u_c, a_s, a_c;

  // pk = h + K + W, built one cycle early: next h is the current g
  always_comb begin
    s1v = big_s1(st_q.e);
    chv = choose(st_q.e, st_q.f, st_q.g);
    s0v = big_s0(st_q.a);
    mjv = majority(st_q.a, st_q.b, st_q.c);
    t_s = csa_sum(pk_q, s1v, chv);
    t_c = csa_cry(pk_q, s1v, chv);
    e_s = csa_sum(t_s, t_c, st_q.d);
    e_c = csa_cry(t_s, t_c, st_q.d);
    u_s = csa_sum(t_s, t_c, s0v);
    u_c = csa_cry(t_s, t_c, s0v);
    a_s = csa_sum(u_s, u_c, mjv);
    a_c = csa_cry(u_s, u_c, mjv);
    nxt.a = a_s + a_c;
    nxt.b = st_q.a;
    nxt.c = st_q.b;
    nxt.d = st_q.c;
    nxt.e = e_s + e_c;
    nxt.f = st_q.e;
    nxt.g = st_q.f;
    nxt.h = st_q.g;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      pk_q <= '0;
    end else begin
      if (load_i)        st_q <= seed_i;
      else if (rnd_en_i) st_q <= nxt;
      if (sb_en_i)       pk_q <= wk_i + (sb_first_i ? st_q.h : st_q.g);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/sha256_digest.sv
module sha256_digest
  import sha256_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fin_i,
  input  state_t work_i,
  input  logic   busy_i,
  input  logic   read_i,
  output state_t hash_o,
  output logic   valid_o,
  output word_t  word_o
);
  localparam logic [DIDX_W-1:0] LAST_IDX = DIDX_W'(DIG_WORDS - 1);

  word_t             h_q    [DIG_WORDS];
  word_t             work_w [DIG_WORDS];
  logic              rd_act_q;
  logic [DIDX_W-1:0] rd_idx_q;
  logic              rd_go;

  for (genvar gi = 0; gi < DIG_WORDS; gi++) begin : g_word
    assign work_w[gi] = work_i[WORD_W*(DIG_WORDS-gi)-1 -: WORD_W];
    assign hash_o[WORD_W*(DIG_WORDS-gi)-1 -: WORD_W] = h_q[gi];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DIG_WORDS; i++) h_q[i] <= iv_word(DIDX_W'(i));
    end else if (fin_i) begin
      for (int i = 0; i < DIG_WORDS; i++) h_q[i] <= h_q[i] + work_w[i];
    end
  end

  assign rd_go = read_i & ~busy_i & ~rd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q <= 1'b0;
      rd_idx_q <= '0;
    end else if (rd_go) begin
      rd_act_q <= 1'b1;
      rd_idx_q <= '0;
    end else if (rd_act_q) begin
      if (rd_idx_q == LAST_IDX) rd_act_q <= 1'b0;
      rd_idx_q <= rd_idx_q + DIDX_W'(1);
    end
  end

  assign valid_o = rd_act_q;
  assign word_o  = h_q[rd_idx_q];
endmodule

// File: rtl/sha256_engine.sv
module sha256_engine
  import sha256_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] word_i,
  input  logic        read_i,
  output logic        ready_o,
  output logic        word_valid_o,
  output logic [31:0] hash_word_o
);
  logic              load, busy, sa_en, sb_en, sb_first, rnd_en, fin;
  logic [RIDX_W-1:0] sa_idx;
  word_t             wk;
  state_t            work, hash;

  sha256_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .load_o     (load),
    .busy_o     (busy),
    .sa_en_o    (sa_en),
    .sa_idx_o   (sa_idx),
    .sb_en_o    (sb_en),
    .sb_first_o (sb_first),
    .rnd_en_o   (rnd_en),
    .fin_o      (fin),
    .ready_o    (ready_o)
  );

  sha256_sched u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sa_en_i  (sa_en),
    .sa_idx_i (sa_idx),
    .word_i   (word_i),
    .wk_o     (wk)
  );

  sha256_round u_round (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .seed_i     (hash),
    .sb_en_i    (sb_en),
    .sb_first_i (sb_first),
    .rnd_en_i   (rnd_en),
    .wk_i       (wk),
    .state_o    (work)
  );

  sha256_digest u_digest (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fin_i   (fin),
    .work_i  (work),
    .busy_i  (busy),
    .read_i  (read_i),
    .hash_o  (hash),
    .valid_o (word_valid_o),
    .word_o  (hash_word_o)
  );
endmodule

// File: rtl/sha256_engine_chk.sv
module sha256_engine_chk
  import sha256_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic read_i,
  input logic ready_o,
  input logic word_valid_o
);
  localparam int unsigned VW = DIDX_W + 1;

  logic              m_busy, due_q;
  logic [STEP_W-1:0] m_cnt;
  logic [VW-1:0]     vrun;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0;
      m_cnt  <= '0;
      due_q  <= 1'b0;
      vrun   <= '0;
    end else begin
      due_q <= m_busy && (m_cnt == STEP_W'(CHUNK_CYCLES));
      if (start_i && !m_busy) begin
        m_busy <= 1'b1;
        m_cnt  <= STEP_W'(1);
      end else if (m_busy && m_cnt == STEP_W'(CHUNK_CYCLES)) begin
        m_busy <= 1'b0;
        m_cnt  <= '0;
      end else if (m_busy) begin
        m_cnt <= m_cnt + STEP_W'(1);
      end
      if (!word_valid_o)              vrun <= '0;
      else if (vrun != VW'(DIG_WORDS)) vrun <= vrun + VW'(1);
    end
  end

  // R3
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  // R3
  ready_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == due_q);

  // R6
  read_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vrun == VW'(DIG_WORDS)) |-> !word_valid_o);

  // R6
  read_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(word_valid_o) |-> (vrun == VW'(DIG_WORDS)));

  // R7
  read_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(word_valid_o) |-> ($past(read_i) && !$past(m_busy)));
endmodule

bind sha256_engine sha256_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .read_i       (read_i),
  .ready_o      (ready_o),
  .word_valid_o (word_valid_o)
);

// File: tb/sha256_engine_tb.sv
`timescale 1ns/1ps
module sha256_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        read = 1'b0;
  logic [31:0] word = '0;
  logic        ready, wvalid;
  logic [31:0] hword;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] kt [64];
  logic [31:0] ivt [8];

  always #2.5 clk = ~clk;

  sha256_engine u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .word_i       (word),
    .read_i       (read),
    .ready_o      (ready),
    .word_valid_o (wvalid),
    .hash_word_o  (hword)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] frac32(input real v);
    real f;
    f = (v - $floor(v)) * 4294967296.0;
    return 32'(longint'($floor(f)));
  endfunction

  function automatic logic [255:0] model(input logic [255:0] hin, input logic [511:0] m);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int t = 0; t < 16; t++) w[t] = m[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    for (int i = 0; i < 8; i++) v[i] = hin[255-32*i -: 32];
    for (int t = 0; t < 64; t++) begin
      t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
      t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255-32*i -: 32] = hin[255-32*i -: 32] + v[i];
    return r;
  endfunction

  task automatic read_digest(input logic [255:0] exp, input bit poke, input string req);
    @(negedge clk); read = 1'b1;
    @(negedge clk); read = 1'b0;
    for (int i = 0; i < 8; i++) begin
      chk(wvalid && hword == exp[255-32*i -: 32], req, 256'({wvalid, hword}), 256'({1'b1, exp[255-32*i -: 32]}));
      read = poke && (i == 3);
      @(negedge clk);
    end
    read = 1'b0;
    chk(!wvalid, "R6 R7 readout ends after eight words", 256'(wvalid), 256'(0));
  endtask

  task automatic run_chunk(input logic [511:0] m, input bit b2b, input bit rd,
                           input logic [255:0] rexp, input bit inject);
    if (!b2b) @(negedge clk);
    start = 1'b1; read = rd;
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      start = 1'b0; read = 1'b0; word = m[511-32*t -: 32];
      if (t == 0) chk(!ready, "R3 ready is a single cycle", 256'(ready), 256'(0));
      if (rd && t < 8)
        chk(wvalid && hword == rexp[255-32*t -: 32], "R9 readout beside word input",
            256'({wvalid, hword}), 256'({1'b1, rexp[255-32*t -: 32]}));
      if (rd && t == 8) chk(!wvalid, "R9 readout length", 256'(wvalid), 256'(0));
    end
    for (int n = 16; n <= 67; n++) begin
      @(negedge clk);
      word = '0; start = 1'b0; read = 1'b0;
      if (inject && n == 30) begin start = 1'b1; read = 1'b1; word = 32'hdeadbeef; end
      chk(ready == (n == 67), "R3 ready 67 cycles after start", 256'(ready), 256'(n == 67));
      if (inject && n >= 31 && n <= 40) chk(!wvalid, "R7 read ignored while busy", 256'(wvalid), 256'(0));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [255:0] iv_all, href, hprev;
    logic [511:0] blk_abc, blk_nil, blk;
    int p, cnt;
    bit prime;

    p = 2; cnt = 0;
    while (cnt < 64) begin
      prime = 1'b1;
      for (int d = 2; d * d <= p; d++) if (p % d == 0) prime = 1'b0;
      if (prime) begin
        kt[cnt] = frac32($pow(real'(p), 1.0 / 3.0));
        if (cnt < 8) ivt[cnt] = frac32($sqrt(real'(p)));
        cnt++;
      end
      p++;
    end
    for (int i = 0; i < 8; i++) iv_all[255-32*i -: 32] = ivt[i];
    blk_abc = {32'h61626380, 448'h0, 32'h00000018};
    blk_nil = {32'h80000000, 480'h0};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ready && !wvalid, "R1 outputs low in reset", 256'({ready, wvalid}), 256'(0));
    rst_n = 1'b1;
    read_digest(iv_all, 1'b0, "R1 initial hash values");
    chk(iv_all == 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19,
        "R1 bench IV", iv_all, 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19);

    // R2 R4: known single chunk
    run_chunk(blk_abc, 1'b0, 1'b0, '0, 1'b0);
    href = model(iv_all, blk_abc);
    chk(href == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
        "R4 bench model known answer", href,
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
    read_digest(href, 1'b1, "R2 R4 digest of single chunk");

    // R8 R7: stray start and read during a chunk
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    run_chunk(blk_nil, 1'b0, 1'b0, '0, 1'b1);
    href = model(iv_all, blk_nil);
    chk(href == 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855,
        "R4 bench model empty message", href,
        256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855);
    read_digest(href, 1'b0, "R8 start ignored mid chunk");

    // R5 R9: chained chunks, back to back, readout overlapping word input
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    href = iv_all;
    for (int k = 0; k < 6; k++) begin
      for (int t = 0; t < 16; t++) blk[511-32*t -: 32] = $urandom;
      hprev = href;
      run_chunk(blk, k > 0, (k % 2) == 1, hprev, 1'b0);
      href = model(hprev, blk);
    end
    read_digest(href, 1'b1, "R5 chained digest");

    // R1: reset abandons a running chunk
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 20; t++) begin word = $urandom; @(negedge clk); end
    rst_n = 1'b0;
    #1;
    chk(!ready && !wvalid, "R1 async reset mid chunk", 256'({ready, wvalid}), 256'(0));
    repeat (2) @(negedge clk); rst_n = 1'b1; word = '0;
    begin
      bit seen;
      seen = 1'b0;
      for (int n = 0; n < 80; n++) begin @(negedge clk); if (ready) seen = 1'b1; end
      chk(!seen, "R1 no ready after abandoned chunk", 256'(seen), 256'(0));
    end
    read_digest(iv_all, 1'b0, "R1 hash restored by reset");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule